// File: doc/BRIEF.md
# Timer Clock Front End

This block sits in front of a multi-channel timer unit and turns three shared source clocks into one divided clock-enable tick per channel. It has ten channels: eight general timer channels (0 to 7), an OS-timer channel (8) and a watchdog channel (9). The source clocks are modelled as synchronous single-cycle enable pulses in the core clock domain. Each channel has a 16-bit control word that picks its source and its prescale code. A shared stop-status word gates all channels. Software changes that word only through a set port and a clear port, and each of those ports acts only on the bits written as one.

Each channel runs a small divider state machine with three states. **DV_STOPPED** holds the pulse counter at zero. **DV_ARMING** captures the current source and prescale settings and clears the counter. **DV_COUNTING** counts pulses of the selected source and emits a tick on every 4^n-th pulse. The transitions are as follows:
- *start* (DV_STOPPED to DV_ARMING) when the stop bit clears.
- *arm* (DV_ARMING to DV_COUNTING) on the next cycle, unless the stop bit is set again.
- *halt* (DV_ARMING or DV_COUNTING to DV_STOPPED) when the stop bit sets.
- *reconfigure* (DV_COUNTING to DV_ARMING) when the channel's source or prescale field differs from the captured copy.

A control word accepts writes only while its channel is running, so software briefly starts a stopped channel before it reprograms that channel.

Top module: `tmr_clk_front`

## Requirements
- R1: After reset, every channel is stopped. The stop-status word reads 0x180FF. Every control word reads zero. No tick is produced even when source pulses arrive.
- R2: A write to address 18 (stop-clear) clears each stop bit written as one. Bits written as zero keep their value. The change shows on the status read in the cycle after the write.
- R3: A write to address 17 (stop-set) sets each stop bit written as one. Bits written as zero keep their value.
- R4: Stop bits 0 to 7 gate channels 0 to 7, bit 15 gates the OS-timer channel 8 and bit 16 gates the watchdog channel 9. All other status bits always read zero. The status word is read at address 16.
- R5: A control word is written and read at the address equal to its channel number (0 to 9). A write while the channel's stop bit is set is ignored. A write while the bit is clear stores all 16 bits.
- R6: Control bits [2:0] are a one-hot source select: bit 0 selects src_pclk_en, bit 1 src_rtc_en and bit 2 src_ext_en. Pulses on sources that are not selected are not counted.
- R7: If none or more than one of control bits [2:0] is set, the channel produces no tick.
- R8: Control bits [5:3] hold a prescale code n. For n = 0 to 5, a running channel ticks on every 4^n-th selected pulse (ratios 1, 4, 16, 64, 256 and 1024).
- R9: Prescale codes 6 and 7 divide by 1024.
- R10: The pulse counter restarts from zero when the channel stops or when its source or prescale field changes. Pulses in the cycle of a start or of a field change, and in the cycle that follows, are not counted.
- R11: A tick is one cycle wide and appears combinationally in the cycle of the qualifying source pulse. It appears only while the channel is running.
- R12: Reads of addresses other than 0 to 9 and 16 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 17 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 17 | Read data (combinational) |
| src_pclk_en | input | 1 | Peripheral source clock enable pulse |
| src_rtc_en | input | 1 | RTC source clock enable pulse |
| src_ext_en | input | 1 | External source clock enable pulse |
| tick | output | 10 | Per-channel divided tick: 0-7 timers, 8 OS timer, 9 watchdog |

## Verification
A divider whose counter is wrong, or one that fails to restart after a stop or a field change, shows up within one divide period as a tick count that differs from the expected quotient. The vector table counts whole pulse trains per channel and per ratio, so such an error appears as a count mismatch. A stop bit or a control word that holds the wrong value is visible on the next read of the register. It is also visible on the first selected pulse, as a tick that appears or goes missing. The checks between pulses catch a stuck or wide tick in the cycle after the pulse.

// File: rtl/tcf_pkg.sv
package tcf_pkg;

    localparam int STOP_W  = 17;
    localparam int OST_BIT = 15;
    localparam int WDT_BIT = 16;
    localparam int SRC_W   = 3;
    localparam int CODE_W  = 3;
    localparam int CFG_W   = SRC_W + CODE_W;

    typedef enum logic [1:0] {
        DV_STOPPED  = 2'd0,
        DV_ARMING   = 2'd1,
        DV_COUNTING = 2'd2
    } div_state_e;

    // Stop-status bit that gates channel ch.
    function automatic int stop_bit_of(input int ch, input int ntmr);
        if (ch < ntmr)       return ch;
        else if (ch == ntmr) return OST_BIT;
        else                 return WDT_BIT;
    endfunction

    // Mask of the status bits that belong to some channel.
    function automatic logic [STOP_W-1:0] stop_mask(input int ntmr);
        logic [STOP_W-1:0] m;
        m = '0;
        for (int c = 0; c < ntmr + 2; c++) m[stop_bit_of(c, ntmr)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/tcf_regs.sv
module tcf_regs
    import tcf_pkg::*;
#(
    parameter int NUM_TMR = 8,
    parameter int CTRL_W  = 16,
    parameter int ADDR_W  = 5,
    parameter int ST_ADDR = 16,
    parameter int SET_ADDR = 17,
    parameter int CLR_ADDR = 18,
    localparam int NUM_CH = NUM_TMR + 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [STOP_W-1:0]               wr_data,
    input  logic [ADDR_W-1:0]               rd_addr,
    output logic [STOP_W-1:0]               rd_data,
    output logic [NUM_CH-1:0]               ch_stopped,
    output logic [NUM_CH-1:0][CFG_W-1:0]    ch_cfg
);

    localparam logic [STOP_W-1:0] MAP_MASK = stop_mask(NUM_TMR);

    logic [STOP_W-1:0]             stop_q;
    logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_q;
    logic                          wr_set, wr_clr;

    assign wr_set = wr_en && (wr_addr == ADDR_W'(SET_ADDR));
    assign wr_clr = wr_en && (wr_addr == ADDR_W'(CLR_ADDR));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= MAP_MASK;
        end else if (wr_set) begin
            stop_q <= stop_q | (wr_data & MAP_MASK);
        end else if (wr_clr) begin
            stop_q <= stop_q & ~(wr_data & MAP_MASK);
        end
    end

    // Stop status changes only through the set and clear ports (R2, R3)
    p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr) |=> $stable(stop_q));
    p_unmapped_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q & ~MAP_MASK) == '0);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int SB = stop_bit_of(c, NUM_TMR);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_q[c] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(c)) && !stop_q[SB]) begin
                ctrl_q[c] <= wr_data[CTRL_W-1:0];
            end
        end

        assign ch_stopped[c] = stop_q[SB];
        assign ch_cfg[c]     = ctrl_q[c][CFG_W-1:0];

        // A stopped channel's control word cannot change (R5)
        p_ctrl_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
            stop_q[SB] |=> $stable(ctrl_q[c]));
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ST_ADDR)) begin
            rd_data = stop_q;
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (rd_addr == ADDR_W'(c)) rd_data = STOP_W'(ctrl_q[c]);
            end
        end
    end

endmodule

// File: rtl/tcf_div.sv
module tcf_div
    import tcf_pkg::*;
#(
    parameter int MAX_CODE = 5,
    localparam int CNT_W = 2 * MAX_CODE,
    localparam int SH_W  = $clog2(CNT_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_i,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic [SRC_W-1:0] src_en_i,
    output logic             tick_o
);

    div_state_e        state_q, state_d;
    logic [CFG_W-1:0]  snap_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  last;
    logic [SH_W-1:0]   shift;
    logic [CODE_W-1:0] code;
    logic              same_cfg, src_ok, pulse, hit;

    assign code     = cfg_i[SRC_W +: CODE_W];
    assign shift    = (code > CODE_W'(MAX_CODE)) ? SH_W'(CNT_W) : SH_W'({code, 1'b0});
    assign last     = ~({CNT_W{1'b1}} << shift);
    assign same_cfg = (cfg_i == snap_q);
    assign src_ok   = $onehot(cfg_i[SRC_W-1:0]);
    assign pulse    = |(src_en_i & cfg_i[SRC_W-1:0]);
    assign hit      = (state_q == DV_COUNTING) && !stop_i && same_cfg && src_ok && pulse;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DV_STOPPED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DV_STOPPED:  if (!stop_i) state_d = DV_ARMING;
            DV_ARMING:   state_d = stop_i ? DV_STOPPED : DV_COUNTING;
            DV_COUNTING: begin
                if (stop_i)         state_d = DV_STOPPED;
                else if (!same_cfg) state_d = DV_ARMING;
            end
            default:     state_d = DV_STOPPED;
        endcase
    end

    // Counter and snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            snap_q <= '0;
        end else begin
            unique case (state_q)
                DV_STOPPED: cnt_q <= '0;
                DV_ARMING: begin
                    cnt_q  <= '0;
                    snap_q <= cfg_i;
                end
                DV_COUNTING: begin
                    if (hit) cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        tick_o = hit && (cnt_q == last);
    end

    p_tick_running_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> !stop_i);
    p_tick_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> |(src_en_i & cfg_i[SRC_W-1:0]));
    p_bad_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(cfg_i[SRC_W-1:0]) != 1) |-> !tick_o);
    p_cfg_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_i) |-> !tick_o);
    p_stop_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_i) |-> !tick_o);

endmodule

// File: rtl/tmr_clk_front.sv
module tmr_clk_front
    import tcf_pkg::*;
#(
    parameter int NUM_TMR  = 8,
    parameter int CTRL_W   = 16,
    parameter int ADDR_W   = 5,
    parameter int MAX_CODE = 5,
    localparam int NUM_CH  = NUM_TMR + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [STOP_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [STOP_W-1:0] rd_data,
    input  logic              src_pclk_en,
    input  logic              src_rtc_en,
    input  logic              src_ext_en,
    output logic [NUM_CH-1:0] tick
);

    logic [NUM_CH-1:0]            ch_stopped;
    logic [NUM_CH-1:0][CFG_W-1:0] ch_cfg;
    logic [SRC_W-1:0]             src_en;

    assign src_en = {src_ext_en, src_rtc_en, src_pclk_en};

    tcf_regs #(
        .NUM_TMR (NUM_TMR),
        .CTRL_W  (CTRL_W),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .ch_stopped (ch_stopped),
        .ch_cfg     (ch_cfg)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_div
        tcf_div #(
            .MAX_CODE (MAX_CODE)
        ) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .stop_i   (ch_stopped[c]),
            .cfg_i    (ch_cfg[c]),
            .src_en_i (src_en),
            .tick_o   (tick[c])
        );
    end

    // A stopped channel never ticks (R1, R11)
    p_stopped_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick & ch_stopped) == '0);

endmodule

// File: tb/test_tmr_clk_front.sv
module test_tmr_clk_front;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [16:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [16:0] rd_data;
    logic [2:0]  src = '0;
    logic [9:0]  tick;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    tmr_clk_front i_tmr_clk_front (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .src_pclk_en (src[0]),
        .src_rtc_en  (src[1]),
        .src_ext_en  (src[2]),
        .tick        (tick)
    );

    localparam int A_ST = 16, A_SET = 17, A_CLR = 18;

    // {channel, control word, source drive mask, pulses, expected ticks}
    localparam int NV = 12;
    localparam logic [47:0] VEC [NV] = '{
        {4'd0, 16'h0001, 4'h1, 12'd5,    12'd5},  // R6 R8 pclk /1
        {4'd1, 16'h000A, 4'h2, 12'd16,   12'd4},  // R8 rtc /4
        {4'd2, 16'h0014, 4'h4, 12'd40,   12'd2},  // R8 ext /16
        {4'd3, 16'h0019, 4'h1, 12'd130,  12'd2},  // R8 pclk /64
        {4'd8, 16'h0022, 4'h2, 12'd600,  12'd2},  // R4 R8 OS timer /256
        {4'd9, 16'h002C, 4'h4, 12'd2100, 12'd2},  // R4 R8 watchdog /1024
        {4'd4, 16'h0031, 4'h1, 12'd1030, 12'd1},  // R9 code 6
        {4'd5, 16'h003A, 4'h2, 12'd1024, 12'd1},  // R9 code 7
        {4'd6, 16'h0002, 4'h5, 12'd10,   12'd0},  // R6 unselected sources
        {4'd7, 16'h0003, 4'h7, 12'd8,    12'd0},  // R7 two sources
        {4'd0, 16'h0000, 4'h7, 12'd8,    12'd0},  // R7 no source
        {4'd7, 16'h0004, 4'h7, 12'd9,    12'd9}   // R6 ext /1
    };

    function automatic int sb(input int ch);
        if (ch < 8)       return ch;
        else if (ch == 8) return 15;
        else              return 16;
    endfunction

    task automatic check(input bit ok, input string req, input int got, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = 17'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        rd_addr = 5'(a);
        #1 v = int'(rd_data);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Apply n pulses with mask m; count ticks of channel ch, stray ticks elsewhere,
    // and ticks seen in the pulse-free cycle after each pulse.
    task automatic pulses(input logic [2:0] m, input int n, input int ch,
                          output int t, output int stray);
        t = 0; stray = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            src = m;
            #2;
            if (tick[ch]) t++;
            if ((tick & ~(10'(1) << ch)) != '0) stray++;
            @(negedge clk);
            src = '0;
            #2;
            if (tick != '0) stray++;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++; n_vec++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        int v, t, s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_ST, v);
        check(v == 'h180FF, "R1 status after reset", v, 'h180FF);
        for (int c = 0; c < 10; c++) begin
            rd(c, v);
            check(v == 0, "R1 control after reset", v, 0);
        end
        pulses(3'b111, 4, 0, t, s);
        check(tick == '0 && s == 0, "R1 no tick while stopped", s, 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            int ch, ctl, np, ex;
            logic [2:0] dm;
            ch  = int'(VEC[i][47:44]);
            ctl = int'(VEC[i][43:28]);
            dm  = VEC[i][26:24];
            np  = int'(VEC[i][23:12]);
            ex  = int'(VEC[i][11:0]);
            wr(A_CLR, 1 << sb(ch));
            wr(ch, ctl);
            rd(ch, v);
            check(v == ctl, "R5 control write while running", v, ctl);
            idle(4);
            pulses(dm, np, ch, t, s);
            check(t == ex, "R8 tick count (vector)", t, ex);
            check(s == 0, "R11 single-cycle tick, no stray", s, 0);
            wr(A_SET, 1 << sb(ch));
        end

        // R4 / R2 / R3 stop-bit handling
        rd(A_ST, v);
        check(v == 'h180FF, "R3 all stopped after vectors", v, 'h180FF);
        wr(A_CLR, 0);
        rd(A_ST, v);
        check(v == 'h180FF, "R2 zeros to clear ignored", v, 'h180FF);
        wr(A_CLR, 'h10001);
        rd(A_ST, v);
        check(v == 'h080FE, "R2 clear bits 0 and 16", v, 'h080FE);
        wr(A_SET, 0);
        rd(A_ST, v);
        check(v == 'h080FE, "R3 zeros to set ignored", v, 'h080FE);
        wr(A_SET, 1);
        rd(A_ST, v);
        check(v == 'h080FF, "R3 set bit 0 only", v, 'h080FF);
        wr(A_CLR, 'h1FFFF);
        rd(A_ST, v);
        check(v == 0, "R4 unmapped bits read zero", v, 0);
        wr(A_SET, 'h1FFFF);
        rd(A_ST, v);
        check(v == 'h180FF, "R4 set all mapped bits", v, 'h180FF);

        // R5 write while stopped ignored (channel 2 holds 0x0014)
        wr(2, 'h0001);
        rd(2, v);
        check(v == 'h0014, "R5 write while stopped ignored", v, 'h0014);
        wr(A_CLR, 1 << 2);
        wr(2, 'hA501);
        rd(2, v);
        check(v == 'hA501, "R5 full 16-bit write while running", v, 'hA501);
        idle(4);
        pulses(3'b001, 3, 2, t, s);
        check(t == 3, "R6 upper control bits do not disturb divide", t, 3);
        wr(A_SET, 1 << 2);

        // R10 restart on field change
        wr(A_CLR, 1);
        wr(0, 'h0009);
        idle(4);
        pulses(3'b001, 3, 0, t, s);
        check(t == 0, "R10 partial count /4", t, 0);
        wr(0, 'h0011);
        idle(4);
        pulses(3'b001, 13, 0, t, s);
        check(t == 0, "R10 counter restarted on prescale change", t, 0);
        pulses(3'b001, 3, 0, t, s);
        check(t == 1, "R10 tick one full period after change", t, 1);

        // R10 restart on stop
        wr(A_CLR, 2);
        wr(1, 'h0009);
        idle(4);
        pulses(3'b001, 3, 1, t, s);
        wr(A_SET, 2);
        wr(A_CLR, 2);
        idle(4);
        pulses(3'b001, 3, 1, t, s);
        check(t == 0, "R10 counter restarted on stop", t, 0);
        pulses(3'b001, 1, 1, t, s);
        check(t == 1, "R10 tick after restart", t, 1);

        // R11 stop takes effect: no tick once stopped
        wr(A_SET, 2);
        pulses(3'b001, 8, 1, t, s);
        check(t == 0, "R11 no tick after stop", t, 0);

        // R12 unused addresses
        rd(12, v);
        check(v == 0, "R12 unused address reads zero", v, 0);
        rd(A_SET, v);
        check(v == 0, "R12 set port reads zero", v, 0);
        rd(A_CLR, v);
        check(v == 0, "R12 clear port reads zero", v, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule